// File: doc/BRIEF.md
# Dual-ALU Steering and Bypass Control

This block is the hazard control for a fully bypassed five-stage integer pipeline that has two ALUs: an early one in the third stage (EX1) and a late one in the fourth stage (EX2/MEM), next to data memory. Each instruction in decode is given exactly one ALU. If both of its sources can be supplied when it enters EX1, it takes the early ALU. If one source comes from an immediately preceding load, or from an immediately preceding instruction that was itself sent to the late ALU, it takes the late ALU instead, and the missing value is bypassed from writeback.

Loads and stores always form their address in the early ALU. An address register that depends on a late producer directly ahead therefore forces one stall cycle. In that cycle the front of the pipe is held and a bubble goes into EX1. Store data is consumed only in EX2/MEM, so it never stalls. The block also generates the operand bypass selects for EX1 and EX2/MEM. It carries each instruction's ALU choice down the pipe in its own flags, which are cleared by reset and by bubbles.

Instruction class is a 2-bit code on every stage: 0 = none/bubble, 1 = ALU (writes its destination), 2 = load (writes its destination), 3 = store (writes no register). Only classes 1 and 2 are register writers. Register 0 never forms a dependency.

Top module: `dual_alu_steer`

## Requirements
- R1: `id_use_alu2` is 1 only when `id_cls` is ALU and a nonzero `id_rs1` or `id_rs2` equals `ex1_rd` of an EX1 instruction that is a load, or an ALU instruction whose `ex1_use_alu2` is 1. In every other case it is 0. A non-writer in EX1 (store or none) never steers.
- R2: `id_use_alu2` is 0 for loads and stores in decode.
- R3: `stall` and `bubble` are 1 in the same cycle exactly when `id_cls` is load or store and a nonzero `id_rs1` equals `ex1_rd` of an EX1 load or late ALU instruction. An ALU instruction in decode never stalls. A stall lasts one cycle when the pipe advances as required.
- R4: A store whose only dependency on a late EX1 producer is through `id_rs2` (store data) does not stall.
- R5: On each clock, `ex1_use_alu2` takes the previous cycle's `id_use_alu2`, or 0 if `stall` was 1. `ex2_use_alu2` takes the previous cycle's `ex1_use_alu2`.
- R6: `ex1_sel_a` and `ex1_sel_b` (for `ex1_rs1` and `ex1_rs2`) are 1 when the EX2/MEM writer's `ex2_rd` matches, else 2 when the WB writer's `wb_rd` matches, else 0 (register file value). The younger stage has priority. An ALU1 user, or an address operand, never selects a late EX2/MEM producer.
- R7: `ex2_sel_a` and `ex2_sel_b` (for `ex2_rs1` and `ex2_rs2`) are 1 when the WB writer's `wb_rd` matches, else 0 (value carried from EX1).
- R8: A source or destination of register 0 produces no steering, stall or bypass select.
- R9: While `rst_n` is 0, `ex1_use_alu2` and `ex2_use_alu2` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_cls | input | 2 | Class of decode instruction |
| id_rs1 | input | RW | Decode source 1 (address for load/store) |
| id_rs2 | input | RW | Decode source 2 (data for store) |
| ex1_cls | input | 2 | Class of EX1 instruction |
| ex1_rd | input | RW | EX1 destination |
| ex1_rs1 | input | RW | EX1 source 1 |
| ex1_rs2 | input | RW | EX1 source 2 |
| ex2_cls | input | 2 | Class of EX2/MEM instruction |
| ex2_rd | input | RW | EX2/MEM destination |
| ex2_rs1 | input | RW | EX2/MEM source 1 |
| ex2_rs2 | input | RW | EX2/MEM source 2 |
| wb_cls | input | 2 | Class of WB instruction |
| wb_rd | input | RW | WB destination |
| id_use_alu2 | output | 1 | Decode instruction goes to the late ALU |
| ex1_use_alu2 | output | 1 | EX1 instruction uses the late ALU |
| ex2_use_alu2 | output | 1 | EX2/MEM instruction uses the late ALU |
| stall | output | 1 | Hold PC and the IF/ID register |
| bubble | output | 1 | Insert a bubble into EX1 |
| ex1_sel_a | output | 2 | EX1 operand A bypass select |
| ex1_sel_b | output | 2 | EX1 operand B bypass select |
| ex2_sel_a | output | 1 | EX2/MEM operand A bypass select |
| ex2_sel_b | output | 1 | EX2/MEM operand B bypass select |

## Verification
The only state is the two carried late-ALU flags. If either is wrong, the error shows at the ports within a cycle or two. A flag lost on EX1 turns a load-after-late-ALU address dependency into a missing `stall`. It also turns an ALU instruction that follows it into a wrong early-ALU choice in the very next decode. A flag left set by a bubble shows up one cycle after the stall as a spurious `ex1_use_alu2`. On the following cycle it appears as a wrong `ex2_use_alu2`. Bypass select errors are purely combinational and appear in the same cycle that the matching stage contents are present.

// File: rtl/dual_alu_steer.sv
module dual_alu_steer #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    id_cls,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic [1:0]    ex1_cls,
  input  logic [RW-1:0] ex1_rd,
  input  logic [RW-1:0] ex1_rs1,
  input  logic [RW-1:0] ex1_rs2,
  input  logic [1:0]    ex2_cls,
  input  logic [RW-1:0] ex2_rd,
  input  logic [RW-1:0] ex2_rs1,
  input  logic [RW-1:0] ex2_rs2,
  input  logic [1:0]    wb_cls,
  input  logic [RW-1:0] wb_rd,
  output logic          id_use_alu2,
  output logic          ex1_use_alu2,
  output logic          ex2_use_alu2,
  output logic          stall,
  output logic          bubble,
  output logic [1:0]    ex1_sel_a,
  output logic [1:0]    ex1_sel_b,
  output logic          ex2_sel_a,
  output logic          ex2_sel_b
);

  localparam logic [1:0] C_ALU   = 2'd1;
  localparam logic [1:0] C_LOAD  = 2'd2;
  localparam logic [1:0] C_STORE = 2'd3;

  localparam logic [1:0] S_REG = 2'd0;
  localparam logic [1:0] S_EX2 = 2'd1;
  localparam logic [1:0] S_WB  = 2'd2;

  function automatic logic hit(input logic [RW-1:0] src, input logic [RW-1:0] dst,
                               input logic [1:0] cls);
    return (src != '0) && (src == dst) && (cls == C_ALU || cls == C_LOAD);
  endfunction

  logic ex1_alu2_q, ex2_alu2_q;
  logic ex1_late, ex2_late, id_is_mem;

  assign ex1_late  = (ex1_cls == C_LOAD) || (ex1_cls == C_ALU && ex1_alu2_q);
  assign ex2_late  = (ex2_cls == C_LOAD) || (ex2_cls == C_ALU && ex2_alu2_q);
  assign id_is_mem = (id_cls == C_LOAD) || (id_cls == C_STORE);

  assign id_use_alu2 = (id_cls == C_ALU) && ex1_late &&
                       (hit(id_rs1, ex1_rd, ex1_cls) || hit(id_rs2, ex1_rd, ex1_cls));

  assign stall  = id_is_mem && ex1_late && hit(id_rs1, ex1_rd, ex1_cls);
  assign bubble = stall;

  assign ex1_sel_a = hit(ex1_rs1, ex2_rd, ex2_cls) ? S_EX2 :
                     hit(ex1_rs1, wb_rd, wb_cls)   ? S_WB  : S_REG;
  assign ex1_sel_b = hit(ex1_rs2, ex2_rd, ex2_cls) ? S_EX2 :
                     hit(ex1_rs2, wb_rd, wb_cls)   ? S_WB  : S_REG;

  assign ex2_sel_a = hit(ex2_rs1, wb_rd, wb_cls);
  assign ex2_sel_b = hit(ex2_rs2, wb_rd, wb_cls);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex1_alu2_q <= 1'b0;
      ex2_alu2_q <= 1'b0;
    end else begin
      ex1_alu2_q <= stall ? 1'b0 : id_use_alu2;
      ex2_alu2_q <= ex1_alu2_q;
    end
  end

  assign ex1_use_alu2 = ex1_alu2_q;
  assign ex2_use_alu2 = ex2_alu2_q;

  AST_MEM_NEVER_ALU2: assert property (@(posedge clk) disable iff (!rst_n)
    id_is_mem |-> !id_use_alu2); // R2

  AST_ALU_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (id_cls == C_ALU) |-> !stall); // R3

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R3

  AST_BUBBLE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex1_use_alu2); // R5

  AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ex1_use_alu2 |=> ex2_use_alu2); // R5

  AST_EX1_A_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (((ex1_cls == C_ALU) && !ex1_use_alu2) || ex1_cls == C_LOAD || ex1_cls == C_STORE)
      && (ex1_sel_a == S_EX2) |-> !ex2_late); // R6

  AST_EX1_B_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex1_cls == C_ALU) && !ex1_use_alu2) && (ex1_sel_b == S_EX2) |-> !ex2_late); // R6

endmodule

// File: tb/dual_alu_steer_tb.sv
module dual_alu_steer_tb;

  localparam logic [1:0] N = 2'd0, A = 2'd1, L = 2'd2, S = 2'd3;

  typedef struct packed {
    logic [1:0] ic; logic [4:0] ir1, ir2;
    logic [1:0] xc; logic [4:0] xd, xr1, xr2;
    logic [1:0] mc; logic [4:0] md, mr1, mr2;
    logic [1:0] wc; logic [4:0] wd;
    logic ea2, est; logic [1:0] esa, esb; logic ema, emb;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TABLE [NV] = '{
    '{A,1,2, N,0,0,0, N,0,0,0, N,0, 0,0,0,0,0,0, 1},  // R1 idle pipe
    '{A,3,4, L,3,0,0, N,0,0,0, N,0, 1,0,0,0,0,0, 1},  // R1 load-use via rs1, no stall
    '{A,4,3, L,3,0,0, N,0,0,0, N,0, 1,0,0,0,0,0, 1},  // R1 load-use via rs2
    '{A,5,3, A,3,0,0, N,0,0,0, N,0, 0,0,0,0,0,0, 1},  // R1 early ALU producer
    '{L,3,0, L,3,0,0, N,0,0,0, N,0, 0,1,0,0,0,0, 3},  // R3 load address on load
    '{S,7,3, L,3,0,0, N,0,0,0, N,0, 0,0,0,0,0,0, 4},  // R4 store data only
    '{S,3,9, L,3,0,0, N,0,0,0, N,0, 0,1,0,0,0,0, 3},  // R3 store address
    '{A,0,0, L,0,0,0, N,0,0,0, N,0, 0,0,0,0,0,0, 8},  // R8 zero reg steering
    '{L,0,0, L,0,0,0, N,0,0,0, N,0, 0,0,0,0,0,0, 8},  // R8 zero reg stall
    '{A,3,0, S,3,0,0, N,0,0,0, N,0, 0,0,0,0,0,0, 1},  // R1 store is no writer
    '{N,0,0, A,9,6,7, A,6,0,0, L,7, 0,0,1,2,0,0, 6},  // R6 EX2 and WB sources
    '{N,0,0, A,9,6,6, A,6,0,0, A,6, 0,0,1,1,0,0, 6},  // R6 youngest wins
    '{N,0,0, A,9,0,0, A,0,0,0, A,0, 0,0,0,0,0,0, 8},  // R8 zero reg bypass
    '{N,0,0, A,9,4,5, S,4,0,0, A,5, 0,0,0,2,0,0, 6},  // R6 store in EX2 ignored
    '{N,0,0, N,0,0,0, A,2,8,9, L,9, 0,0,0,0,0,1, 7},  // R7 WB to EX2
    '{N,0,0, N,0,0,0, A,2,9,9, S,9, 0,0,0,0,0,0, 7}   // R7 store in WB ignored
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] id_cls, ex1_cls, ex2_cls, wb_cls;
  logic [4:0] id_rs1, id_rs2, ex1_rd, ex1_rs1, ex1_rs2, ex2_rd, ex2_rs1, ex2_rs2, wb_rd;
  logic id_use_alu2, ex1_use_alu2, ex2_use_alu2, stall, bubble, ex2_sel_a, ex2_sel_b;
  logic [1:0] ex1_sel_a, ex1_sel_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_alu_steer #(.RW(5)) u_dut (
    .clk, .rst_n, .id_cls, .id_rs1, .id_rs2, .ex1_cls, .ex1_rd, .ex1_rs1, .ex1_rs2,
    .ex2_cls, .ex2_rd, .ex2_rs1, .ex2_rs2, .wb_cls, .wb_rd, .id_use_alu2,
    .ex1_use_alu2, .ex2_use_alu2, .stall, .bubble, .ex1_sel_a, .ex1_sel_b,
    .ex2_sel_a, .ex2_sel_b);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] ic, input int ir1, input int ir2,
                     input logic [1:0] xc, input int xd, input int xr1, input int xr2,
                     input logic [1:0] mc, input int md, input int mr1, input int mr2,
                     input logic [1:0] wc, input int wd);
    id_cls = ic;  id_rs1 = 5'(ir1); id_rs2 = 5'(ir2);
    ex1_cls = xc; ex1_rd = 5'(xd); ex1_rs1 = 5'(xr1); ex1_rs2 = 5'(xr2);
    ex2_cls = mc; ex2_rd = 5'(md); ex2_rs1 = 5'(mr1); ex2_rs2 = 5'(mr2);
    wb_cls = wc;  wb_rd = 5'(wd);
  endtask

  task automatic idle();
    put(N,0,0, N,0,0,0, N,0,0,0, N,0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R9: flags held at zero in reset while decode would steer late
    put(A,3,0, L,3,0,0, N,0,0,0, N,0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 ex1_use_alu2 in reset", 32'(ex1_use_alu2), 0);
    chk("R9 ex2_use_alu2 in reset", 32'(ex2_use_alu2), 0);
    idle();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic r;
      v = TABLE[i];
      r = v.est ? 1'b0 : v.ea2;
      @(negedge clk);
      put(v.ic, v.ir1, v.ir2, v.xc, v.xd, v.xr1, v.xr2, v.mc, v.md, v.mr1, v.mr2, v.wc, v.wd);
      #1;
      chk($sformatf("R%0d vector %0d outputs", v.req, i),
          32'({id_use_alu2, stall, bubble, ex1_sel_a, ex1_sel_b, ex2_sel_a, ex2_sel_b}),
          32'({v.ea2, v.est, v.est, v.esa, v.esb, v.ema, v.emb}));
      @(negedge clk);
      chk($sformatf("R5 vector %0d ex1 flag", i), 32'(ex1_use_alu2), 32'(r));
      idle();
      @(negedge clk);
      chk($sformatf("R5 vector %0d ex2 flag", i), 32'(ex2_use_alu2), 32'(r));
      @(posedge clk);
    end

    // Directed: load r3; alu r4=r3,r2 (late); load addr r4 (stall); alu r6=r5,r4 (late)
    @(negedge clk); put(L,1,0, N,0,0,0, N,0,0,0, N,0); #1;
    chk("R3 c0 no stall", 32'(stall), 0);
    @(negedge clk); put(A,3,2, L,3,1,0, N,0,0,0, N,0); #1;
    chk("R1 c1 late after load", 32'(id_use_alu2), 1);
    @(negedge clk); put(L,4,0, A,4,3,2, L,3,1,0, N,0); #1;
    chk("R5 c2 ex1 flag", 32'(ex1_use_alu2), 1);
    chk("R3 c2 stall+bubble", 32'({stall, bubble}), 32'b11);
    @(negedge clk); put(L,4,0, N,0,0,0, A,4,3,2, L,3); #1;
    chk("R3 c3 stall released", 32'(stall), 0);
    chk("R5 c3 bubble flag", 32'(ex1_use_alu2), 0);
    chk("R5 c3 ex2 flag", 32'(ex2_use_alu2), 1);
    chk("R7 c3 ex2_sel_a from WB", 32'(ex2_sel_a), 1);
    @(negedge clk); put(A,5,4, L,5,4,0, N,0,0,0, A,4); #1;
    chk("R1 c4 late after load", 32'(id_use_alu2), 1);
    chk("R6 c4 address from WB", 32'(ex1_sel_a), 2);
    @(negedge clk); put(N,0,0, A,6,5,4, L,5,4,0, N,0); #1;
    chk("R5 c5 ex1 flag", 32'(ex1_use_alu2), 1);
    chk("R6 c5 sel_a/sel_b", 32'({ex1_sel_a, ex1_sel_b}), 32'b0100);
    @(negedge clk); put(N,0,0, N,0,0,0, A,6,5,4, L,5); #1;
    chk("R5 c6 ex2 flag", 32'(ex2_use_alu2), 1);
    chk("R7 c6 ex2 sels", 32'({ex2_sel_a, ex2_sel_b}), 32'b10);
    @(negedge clk); idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule